// File: doc/BRIEF.md
# Key Event Queue with Indexed Peek

This block holds the most recent key events of a keypad controller in a small circular buffer. Every event arrives on a one-cycle strobe with a 7-bit key code and a press/release flag. It is stored as one byte and raises the keypad interrupt flag. The host drains the queue through two kinds of read. A consuming read steps the head forward before it fetches, so one entry always stays behind. A non-consuming peek addresses an entry relative to the current head.

When the queue already holds sixteen entries, an incoming event is lost and an overflow error is raised. While both the error-status flag and the sticky overflow flag are set, further events are dropped silently. A status acknowledge clears the error-status flag, and the queue then accepts events again. A configuration write empties the queue and clears the interrupt flags. All read results appear on a registered data port one cycle after the request.

Top module: `key_event_queue`

## Requirements
- R1: An accepted event is stored as the byte {press, code[6:0]}: bit 7 is the press flag (1 = pressed, 0 = released) and bits 6:0 are the key code.
- R2: An accepted event goes to slot (head + length) mod 16, increments the length and sets `kp_int`.
- R3: An event that arrives while the length is 16 and the drop gate is open is discarded. The stored contents are left unchanged, and both `err_int` and `ovf_err` are set.
- R4: While `err_int` and `ovf_err` are both 1, incoming events are discarded with no effect on contents, length or flags.
- R5: A consuming read (`rd_peek`=0) with length ≤ 1 returns 0 and changes nothing. Otherwise it advances the head by one modulo 16, decrements the length, and returns the entry at the new head.
- R6: A peek read (`rd_peek`=1) with index i returns the entry at (head + i) mod 16 when i < length, and 0 otherwise. It changes no state.
- R7: `cfg_wr` sets head and length to 0 and clears `kp_int` and `err_int`. An event in the same cycle is discarded. `ovf_err` is cleared only by reset.
- R8: `status_ack` clears `kp_int` and `err_int`. A flag set by an event in the same cycle takes precedence over the clear.
- R9: When a consuming read and an event occur in the same cycle, the read updates the pointers first. The event is then placed and checked for overflow using the post-read length, so a full queue accepts it.
- R10: Every read request gives `rd_ack`=1 with its result on `rd_data` exactly one cycle later. `irq_n` is 0 whenever `kp_int` or `err_int` is 1.
- R11: After reset the queue is empty, all flags are 0, `rd_ack` and `rd_data` are 0, and `irq_n` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ev_valid | input | 1 | Key event strobe |
| ev_code | input | 7 | Key code of the event |
| ev_press | input | 1 | 1 = press, 0 = release |
| cfg_wr | input | 1 | Configuration write: empties the queue |
| status_ack | input | 1 | Host status read: clears interrupt flags |
| rd_valid | input | 1 | Read request |
| rd_peek | input | 1 | 0 = consuming read, 1 = peek |
| rd_index | input | 5 | Peek index relative to head |
| rd_ack | output | 1 | Read result valid |
| rd_data | output | 8 | Read result |
| kp_int | output | 1 | Keypad interrupt flag |
| err_int | output | 1 | Error interrupt flag |
| ovf_err | output | 1 | Sticky queue-overflow error |
| irq_n | output | 1 | Active-low interrupt |

## Verification
A head pointer that drifts by one shows on the next consuming read or peek, because the returned byte comes from a neighbouring slot. A length that is off by one changes where a peek starts returning 0, and when overflow is flagged. The bench therefore keeps its own queue and compares `rd_data`, `rd_ack` and every flag on every cycle. A wrong internal value is reported at the first read or event that depends on it. Directed sequences wrap the pointers, fill the queue to its limit, and line up pops, events, acknowledges and configuration writes in the same cycle.

// File: rtl/keyq_pkg.sv
package keyq_pkg;
    typedef enum logic {
        RD_POP  = 1'b0,
        RD_PEEK = 1'b1
    } rd_kind_e;

    function automatic logic [7:0] keyq_encode(input logic press, input logic [6:0] code);
        return {press, code};
    endfunction
endpackage

// File: rtl/keyq_store.sv
module keyq_store #(
    parameter int DEPTH = 16,
    parameter int DW    = 8,
    localparam int PW   = $clog2(DEPTH)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          wr_en,
    input  logic [PW-1:0] wr_addr,
    input  logic [DW-1:0] wr_data,
    input  logic [PW-1:0] rd_addr,
    output logic [DW-1:0] rd_data
);
    logic [DW-1:0] slot_q [DEPTH];
    logic [DW-1:0] slot_d [DEPTH];

    always_comb begin
        slot_d = slot_q;
        if (wr_en) slot_d[wr_addr] = wr_data;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int k = 0; k < DEPTH; k++) slot_q[k] <= '0;
        end else begin
            slot_q <= slot_d;
        end
    end

    assign rd_data = slot_q[rd_addr];
endmodule

// File: rtl/keyq_ctrl.sv
module keyq_ctrl
    import keyq_pkg::*;
#(
    parameter int DEPTH = 16,
    localparam int PW   = $clog2(DEPTH),
    localparam int LW   = PW + 1
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          ev_valid,
    input  logic          drop_gate,
    input  logic          cfg_wr,
    input  logic          rd_valid,
    input  rd_kind_e      rd_kind,
    input  logic [LW-1:0] rd_index,
    output logic          wr_en,
    output logic [PW-1:0] wr_addr,
    output logic [PW-1:0] rd_addr,
    output logic          rd_hit,
    output logic          ev_accept,
    output logic          ev_overflow
);
    typedef struct packed {
        logic [PW-1:0] head;
        logic [LW-1:0] len;
    } ptr_t;

    ptr_t ptr_q, ptr_d;
    logic pop_ok;

    always_comb begin
        ptr_d       = ptr_q;
        ev_accept   = 1'b0;
        ev_overflow = 1'b0;
        wr_addr     = '0;
        pop_ok      = rd_valid && (rd_kind == RD_POP) && (ptr_q.len > LW'(1));

        if (rd_kind == RD_PEEK) begin
            rd_addr = ptr_q.head + rd_index[PW-1:0];
            rd_hit  = rd_index < ptr_q.len;
        end else begin
            rd_addr = ptr_q.head + PW'(1);
            rd_hit  = pop_ok;
        end

        // read side updates the pointers first
        if (pop_ok) begin
            ptr_d.head = ptr_q.head + PW'(1);
            ptr_d.len  = ptr_q.len - LW'(1);
        end

        // event placed against the post-read state
        if (ev_valid && !drop_gate) begin
            if (ptr_d.len == LW'(DEPTH)) begin
                ev_overflow = 1'b1;
            end else begin
                ev_accept = 1'b1;
                wr_addr   = ptr_d.head + ptr_d.len[PW-1:0];
                ptr_d.len = ptr_d.len + LW'(1);
            end
        end

        if (cfg_wr) begin
            ptr_d       = '0;
            ev_accept   = 1'b0;
            ev_overflow = 1'b0;
        end
        wr_en = ev_accept;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) ptr_q <= '0;
        else        ptr_q <= ptr_d;
    end

    assert_len_bound_R3: assert property (@(posedge clk) disable iff (!rst_n)
        ptr_q.len <= LW'(DEPTH));

    assert_pop_short_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_valid && rd_kind == RD_POP && ptr_q.len <= LW'(1) && !cfg_wr)
        |=> $stable(ptr_q.head));

    assert_pop_step_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_valid && rd_kind == RD_POP && ptr_q.len > LW'(1) && !cfg_wr)
        |=> ptr_q.head == $past(ptr_q.head) + PW'(1));

    assert_peek_still_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_valid && rd_kind == RD_PEEK && !ev_valid && !cfg_wr)
        |=> $stable(ptr_q.len) && $stable(ptr_q.head));

    assert_cfg_clear_R7: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_wr |=> (ptr_q.len == '0) && (ptr_q.head == '0));
endmodule

// File: rtl/keyq_flags.sv
module keyq_flags (
    input  logic clk,
    input  logic rst_n,
    input  logic ev_accept,
    input  logic ev_overflow,
    input  logic cfg_wr,
    input  logic status_ack,
    output logic kp_int,
    output logic err_int,
    output logic ovf_err,
    output logic drop_gate
);
    typedef struct packed {
        logic kp;
        logic err;
        logic ovf;
    } flag_t;

    flag_t flag_q, flag_d;

    always_comb begin
        flag_d = flag_q;
        if (status_ack || cfg_wr) begin
            flag_d.kp  = 1'b0;
            flag_d.err = 1'b0;
        end
        if (ev_accept) flag_d.kp = 1'b1;
        if (ev_overflow) begin
            flag_d.err = 1'b1;
            flag_d.ovf = 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) flag_q <= '0;
        else        flag_q <= flag_d;
    end

    assign kp_int    = flag_q.kp;
    assign err_int   = flag_q.err;
    assign ovf_err   = flag_q.ovf;
    assign drop_gate = flag_q.err && flag_q.ovf;

    assert_ovf_flag_R3: assert property (@(posedge clk) disable iff (!rst_n)
        ev_overflow |=> err_int && ovf_err);

    assert_ack_clear_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (status_ack && !ev_accept && !ev_overflow) |=> !kp_int && !err_int);

    assert_accept_flag_R2: assert property (@(posedge clk) disable iff (!rst_n)
        ev_accept |=> kp_int);
endmodule

// File: rtl/key_event_queue.sv
module key_event_queue
    import keyq_pkg::*;
#(
    parameter int DEPTH  = 16,
    parameter int CODE_W = 7,
    localparam int PW    = $clog2(DEPTH),
    localparam int IW    = PW + 1,
    localparam int DW    = CODE_W + 1
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          ev_valid,
    input  logic [CODE_W-1:0] ev_code,
    input  logic          ev_press,
    input  logic          cfg_wr,
    input  logic          status_ack,
    input  logic          rd_valid,
    input  logic          rd_peek,
    input  logic [IW-1:0] rd_index,
    output logic          rd_ack,
    output logic [DW-1:0] rd_data,
    output logic          kp_int,
    output logic          err_int,
    output logic          ovf_err,
    output logic          irq_n
);
    typedef struct packed {
        logic          ack;
        logic [DW-1:0] data;
    } rdout_t;

    rdout_t   rdo_q, rdo_d;
    rd_kind_e rd_kind;
    logic          drop_gate, wr_en, rd_hit, ev_accept, ev_overflow;
    logic [PW-1:0] wr_addr, rd_addr;
    logic [DW-1:0] slot_data;

    assign rd_kind = rd_peek ? RD_PEEK : RD_POP;

    keyq_ctrl #(.DEPTH(DEPTH)) u_ctrl (
        .clk, .rst_n, .ev_valid, .drop_gate, .cfg_wr, .rd_valid, .rd_kind,
        .rd_index, .wr_en, .wr_addr, .rd_addr, .rd_hit, .ev_accept, .ev_overflow
    );

    keyq_store #(.DEPTH(DEPTH), .DW(DW)) u_store (
        .clk, .rst_n, .wr_en, .wr_addr,
        .wr_data(keyq_encode(ev_press, ev_code)),
        .rd_addr, .rd_data(slot_data)
    );

    keyq_flags u_flags (
        .clk, .rst_n, .ev_accept, .ev_overflow, .cfg_wr, .status_ack,
        .kp_int, .err_int, .ovf_err, .drop_gate
    );

    always_comb begin
        rdo_d.ack  = rd_valid;
        rdo_d.data = (rd_valid && rd_hit) ? slot_data : '0;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) rdo_q <= '0;
        else        rdo_q <= rdo_d;
    end

    assign rd_ack  = rdo_q.ack;
    assign rd_data = rdo_q.data;
    assign irq_n   = !(kp_int || err_int);

    assert_gate_drop_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (err_int && ovf_err) |-> !ev_accept && !ev_overflow);

    assert_rd_ack_R10: assert property (@(posedge clk) disable iff (!rst_n)
        rd_valid |=> rd_ack);

    assert_no_ack_R10: assert property (@(posedge clk) disable iff (!rst_n)
        !rd_valid |=> !rd_ack && rd_data == '0);
endmodule

// File: tb/test_key_event_queue.sv
module test_key_event_queue;
    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic ev_valid = 0, ev_press = 0, cfg_wr = 0, status_ack = 0, rd_valid = 0, rd_peek = 0;
    logic [6:0] ev_code = '0;
    logic [4:0] rd_index = '0;
    logic rd_ack, kp_int, err_int, ovf_err, irq_n;
    logic [7:0] rd_data;

    int total = 0;
    int bad = 0;
    bit finished = 0;

    always #5 clk = ~clk;

    key_event_queue i_key_event_queue (
        .clk, .rst_n, .ev_valid, .ev_code, .ev_press, .cfg_wr, .status_ack,
        .rd_valid, .rd_peek, .rd_index, .rd_ack, .rd_data, .kp_int, .err_int,
        .ovf_err, .irq_n
    );

    // behavioural reference model
    int m_mem [16];
    int m_head = 0, m_len = 0;
    bit m_kp = 0, m_err = 0, m_ovf = 0, m_ack = 0, m_lastpeek = 0;
    int m_data = 0;

    initial for (int k = 0; k < 16; k++) m_mem[k] = 0;

    always @(posedge clk) begin
        if (rst_n) begin
            bit gate, acc, ovfl;
            int h, l;
            gate = m_err && m_ovf;
            m_ack = rd_valid;
            m_lastpeek = rd_peek;
            if (!rd_valid) m_data = 0;
            else if (rd_peek) m_data = (rd_index < m_len) ? m_mem[(m_head + rd_index) % 16] : 0;
            else m_data = (m_len > 1) ? m_mem[(m_head + 1) % 16] : 0;
            h = m_head; l = m_len; acc = 0; ovfl = 0;
            if (rd_valid && !rd_peek && l > 1) begin h = (h + 1) % 16; l = l - 1; end
            if (ev_valid && !gate && !cfg_wr) begin
                if (l == 16) ovfl = 1;
                else begin
                    m_mem[(h + l) % 16] = ev_press * 128 + ev_code;
                    l = l + 1; acc = 1;
                end
            end
            if (cfg_wr) begin h = 0; l = 0; end
            m_head = h; m_len = l;
            if (status_ack || cfg_wr) begin m_kp = 0; m_err = 0; end
            if (acc) m_kp = 1;
            if (ovfl) begin m_err = 1; m_ovf = 1; end
        end
    end

    task automatic chk(input string tag, input int act, input int exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s: actual=%0h expected=%0h at %0t", tag, act, exp, $time);
        end
    endtask

    // per-cycle comparison against the model
    always @(negedge clk) begin
        if (rst_n && !finished) begin
            chk("R10 rd_ack", rd_ack, m_ack);
            chk(m_lastpeek ? "R6 peek data" : "R5 pop data", rd_data, m_data);
            chk("R2 kp_int", kp_int, m_kp);
            chk("R3 err_int", err_int, m_err);
            chk("R3 ovf_err", ovf_err, m_ovf);
            chk("R10 irq_n", irq_n, !(m_kp || m_err));
        end
    end

    task automatic cyc(input bit ev, input int code, input bit press, input bit rd,
                       input bit pk, input int idx, input bit cfg, input bit ack);
        ev_valid = ev; ev_code = code[6:0]; ev_press = press;
        rd_valid = rd; rd_peek = pk; rd_index = idx[4:0];
        cfg_wr = cfg; status_ack = ack;
        @(negedge clk);
        ev_valid = 0; rd_valid = 0; rd_peek = 0; cfg_wr = 0; status_ack = 0;
    endtask

    task automatic push(input int code, input bit press);
        cyc(1, code, press, 0, 0, 0, 0, 0);
    endtask
    task automatic pop();
        cyc(0, 0, 0, 1, 0, 0, 0, 0);
    endtask
    task automatic peek(input int idx);
        cyc(0, 0, 0, 1, 1, idx, 0, 0);
    endtask

    initial begin
        #2_000_000;
        if (!finished) begin
            finished = 1;
            total++; bad++;
            $display("FAIL watchdog: actual=hung expected=done");
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        // R11 reset state
        chk("R11 rd_ack", rd_ack, 0);
        chk("R11 rd_data", rd_data, 0);
        chk("R11 flags", {kp_int, err_int, ovf_err}, 0);
        chk("R11 irq_n", irq_n, 1);
        rst_n = 1;
        @(negedge clk);

        // R1 encoding, R2 flag
        push(7'h3c, 1);
        chk("R2 kp_int set", kp_int, 1);
        peek(0);
        chk("R1 encoded byte", rd_data, 8'hbc);
        // R5 last entry kept
        pop();
        chk("R5 short pop", rd_data, 0);
        peek(0);
        chk("R5 entry kept", rd_data, 8'hbc);
        push(7'h11, 0);
        pop();
        chk("R5 pop value", rd_data, 8'h11);
        peek(1);
        chk("R6 beyond length", rd_data, 0);
        // R8 ack and precedence
        cyc(0, 0, 0, 0, 0, 0, 0, 1);
        chk("R8 ack clears", kp_int, 0);
        cyc(1, 7'h05, 1, 0, 0, 0, 0, 1);
        chk("R8 set wins", kp_int, 1);
        // R7 config clears
        cyc(0, 0, 0, 0, 0, 0, 1, 0);
        chk("R7 kp cleared", kp_int, 0);
        peek(0);
        chk("R7 emptied", rd_data, 0);

        // wrap and fill
        push(7'h20, 0); push(7'h21, 0); push(7'h22, 0);
        pop();
        chk("R5 pop 1", rd_data, 8'h21);
        pop();
        chk("R5 pop 2", rd_data, 8'h22);
        for (int k = 0; k < 15; k++) push(7'h40 + k, 0);
        peek(15);
        chk("R6 wrapped peek", rd_data, 8'h4e);
        chk("R3 no error yet", err_int, 0);
        push(7'h7f, 1);
        chk("R3 err_int", err_int, 1);
        chk("R3 ovf_err", ovf_err, 1);
        peek(15);
        chk("R3 contents kept", rd_data, 8'h4e);

        // R4 silent drop while gated
        pop();
        chk("R5 pop after full", rd_data, 8'h40);
        push(7'h55, 0);
        peek(15);
        chk("R4 event ignored", rd_data, 0);
        cyc(0, 0, 0, 0, 0, 0, 0, 1);
        chk("R4 err cleared", err_int, 0);
        push(7'h56, 1);
        peek(15);
        chk("R4 accepted after ack", rd_data, 8'hd6);

        // R9 pop and event together on a full queue
        cyc(1, 7'h57, 0, 1, 0, 0, 0, 0);
        chk("R9 pop value", rd_data, 8'h41);
        chk("R9 no overflow", err_int, 0);
        peek(15);
        chk("R9 event placed", rd_data, 8'h57);
        push(7'h58, 0);
        chk("R3 overflow again", err_int, 1);
        cyc(0, 0, 0, 0, 0, 0, 1, 0);
        chk("R7 err cleared", err_int, 0);
        chk("R7 ovf sticky", ovf_err, 1);

        // mixed traffic checked by the model
        for (int n = 0; n < 3000; n++) begin
            cyc($urandom % 2, $urandom % 128, $urandom % 2, ($urandom % 3) == 0,
                $urandom % 2, $urandom % 20, ($urandom % 60) == 0, ($urandom % 10) == 0);
        end

        finished = 1;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule